// File: doc/BRIEF.md
# Coprocessor Command Bridge with Region Decoder

This block sits between a processor's extended-function command port and a local interconnect that serves several targets. The processor sends two kinds of operation: writes, and reads that are split into an issue command and a later collect command. Each command carries a pair of 32-bit values. With explicit addressing, the pair is an address and one data word. With auto-increment addressing, the pair is 64 bits of data, and the bridge supplies the address from a held pointer that moves forward by itself.

The bridge keeps a 20-bit held address. It breaks every transfer into 32-bit beats and decodes each beat address onto one of seven windows: a shared memory, a large configuration bank, a sequencer data store, a sequencer instruction store, a system-control bank and two accelerator banks. It runs a request/acknowledge handshake toward the selected target. A beat that lands in an unmapped gap never reaches the bus and is reported on a one-cycle error pulse.

The command port and the response port are both valid/ready streams. A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a bus sequence runs, and it also stays low while a response waits to be taken. A response stays on `rsp_data` until `rsp_ready` takes it.

Top module: `cop_bridge`

## Requirements
- R1: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a bus sequence is in progress and while `rsp_valid` is high. `busy` is high on any cycle where a collect command (op 2 or 3) is offered while a sequence is still in progress.
- R2: An explicit write (`cmd_op`=0, `cmd_auto`=0) makes one write beat of `cmd_hi` to `cmd_lo[19:0]`. Bits 31:20 of `cmd_lo` are ignored. The command also loads the held address with `cmd_lo[19:0]`.
- R3: An auto write (`cmd_op`=0, `cmd_auto`=1) writes `cmd_lo` to the held address and then `cmd_hi` to the held address + 4. It then advances the held address by 8.
- R4: A read issue (`cmd_op`=1) fetches the two consecutive words at A and A+4, lowest address first. A is `cmd_lo[19:0]` in explicit mode, and the command also loads the held address with it. In auto mode A is the held address, and the held address is left unchanged at issue.
- R5: A 32-bit collect (`cmd_op`=2) returns {32'h0, word at A}. A 64-bit collect (`cmd_op`=3) returns {word at A+4, word at A}. If the read was issued in auto mode, the collect advances the held address by 4 for op 2 or by 8 for op 3.
- R6: Beat addresses decode to one-hot `bus_sel` bits: bit0 0x00000–0x07FFF, bit1 0x20000–0x3FFFF, bit2 0x94000–0x94FFF, bit3 0x98000–0x99FFF, bit4 0x9C000–0x9CFFF, bit5 0xA0000–0xA0FFF, bit6 0xA1000–0xA1FFF.
- R7: A beat outside every window makes no bus request. A write beat there is dropped, and a read beat there yields zero. A command that touched a gap raises `err` for exactly one cycle after its sequence ends.
- R8: A collect with no fetched read outstanding returns all zeros and raises `err` for one cycle.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays stable.
- R10: `bus_req` stays high with stable `bus_addr`, `bus_we`, `bus_wdata` and `bus_sel` until a cycle with `bus_ack` high.
- R11: After reset, `cmd_ready` is high, `rsp_valid`, `bus_req` and `err` are low, and the held address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 2 | 0 write, 1 read issue, 2 collect 32-bit, 3 collect 64-bit |
| cmd_auto | input | 1 | 1 selects auto-increment addressing |
| cmd_lo | input | 32 | Address (explicit) or low data word (auto) |
| cmd_hi | input | 32 | Write data (explicit) or high data word (auto) |
| rsp_valid | output | 1 | Collect response available |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 64 | Collected read data |
| busy | output | 1 | A collect is stalled behind an unfinished read |
| err | output | 1 | One-cycle pulse on a gap access or a collect with no read outstanding |
| bus_req | output | 1 | Beat request toward targets |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 20 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_sel | output | 7 | One-hot target window select |
| bus_ack | input | 1 | Target completes the beat |
| bus_rdata | input | 32 | Read data, valid with bus_ack |

## Verification
The bench first runs an auto write straight after reset. A design that did not clear the held address, or that moved it by the wrong step, would place those beats, and every later auto transfer, at wrong addresses. It issues a read against a slow target and offers the collect at once. A bridge that ignored the pending read would answer with stale data and never raise `busy`. A 64-bit read that straddles the top of the shared memory must return zero in its upper half and pulse `err`. A design that decoded only the first beat would instead issue a bus request into the gap. The bench also collects with no read outstanding, interleaves 32-bit and 64-bit auto collects so that a wrong pointer step shows up in the next auto write, and holds `rsp_ready` low to catch a response that changes or disappears.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam int ADDR_W   = 20;
  localparam int DATA_W   = 32;
  localparam int N_REGION = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_ISSUE = 2'b01,
    OP_COL32 = 2'b10,
    OP_COL64 = 2'b11
  } cbr_op_e;

  // Window base addresses; the sel bit index is the window index.
  function automatic logic [ADDR_W-1:0] region_base(input int idx);
    logic [ADDR_W-1:0] b;
    case (idx)
      0:       b = 20'h00000;  // shared memory
      1:       b = 20'h20000;  // transfer-engine configuration bank
      2:       b = 20'h94000;  // sequencer data store
      3:       b = 20'h98000;  // sequencer instruction store
      4:       b = 20'h9C000;  // system-control bank
      5:       b = 20'hA0000;  // accelerator bank 0
      default: b = 20'hA1000;  // accelerator bank 1
    endcase
    return b;
  endfunction

  // Window size minus one; every window is a power of two and aligned.
  function automatic logic [ADDR_W-1:0] region_mask(input int idx);
    logic [ADDR_W-1:0] m;
    case (idx)
      0:       m = 20'h07FFF;
      1:       m = 20'h1FFFF;
      2:       m = 20'h00FFF;
      3:       m = 20'h01FFF;
      4:       m = 20'h00FFF;
      5:       m = 20'h00FFF;
      default: m = 20'h00FFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cbr_addr_dec.sv
module cbr_addr_dec
  import cbr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int NR = N_REGION
) (
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] sel_o,
  output logic          hole_o
);

  for (genvar g = 0; g < NR; g++) begin : g_win
    localparam logic [AW-1:0] WBASE = AW'(region_base(g));
    localparam logic [AW-1:0] WMASK = AW'(region_mask(g));
    assign sel_o[g] = ((addr_i & ~WMASK) == WBASE);
  end

  assign hole_o = ~|sel_o;

endmodule

// File: rtl/cbr_beat_seq.sv
module cbr_beat_seq
  import cbr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = N_REGION
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic            we_i,
  input  logic            two_i,
  input  logic [AW-1:0]   base_i,
  input  logic [2*DW-1:0] wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic [2*DW-1:0] rdata_o,
  output logic            req_o,
  output logic            we_o,
  output logic [AW-1:0]   addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic [NR-1:0]   sel_o,
  input  logic            ack_i,
  input  logic [DW-1:0]   rdata_i
);

  localparam int WW = 2 * DW;
  localparam logic [AW-1:0] BEAT_STEP = AW'(DW / 8);

  logic            run_q, idx_q, two_q, we_q, err_q, done_q;
  logic [AW-1:0]   base_q;
  logic [WW-1:0]   wd_q, rd_q;
  logic [AW-1:0]   cur_addr;
  logic [NR-1:0]   sel;
  logic            hole, step, last;

  assign cur_addr = base_q + (idx_q ? BEAT_STEP : '0);

  cbr_addr_dec #(.AW(AW), .NR(NR)) u_dec (
    .addr_i (cur_addr),
    .sel_o  (sel),
    .hole_o (hole)
  );

  assign last = idx_q | ~two_q;
  assign step = run_q & (hole | ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= 1'b0;
      two_q  <= 1'b0;
      we_q   <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      base_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        run_q  <= 1'b1;
        idx_q  <= 1'b0;
        two_q  <= two_i;
        we_q   <= we_i;
        err_q  <= 1'b0;
        base_q <= base_i;
        wd_q   <= wdata_i;
        rd_q   <= '0;
      end else if (step) begin
        if (hole) err_q <= 1'b1;
        else if (!we_q) rd_q[int'(idx_q)*DW +: DW] <= rdata_i;
        if (last) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o  = run_q | done_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign rdata_o = rd_q;
  assign req_o   = run_q & ~hole;
  assign we_o    = we_q;
  assign addr_o  = cur_addr;
  assign wdata_o = wd_q[int'(idx_q)*DW +: DW];
  assign sel_o   = sel;

  // R6: at most one window is selected while a sequence is running
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $onehot0(sel_o));

  // R10: an unacknowledged request keeps its beat stable
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(we_o)
                           && $stable(wdata_o) && $stable(sel_o)));

endmodule

// File: rtl/cbr_rd_buf.sv
module cbr_rd_buf #(
  parameter int WW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [WW-1:0] data_i,
  input  logic          take_i,
  output logic          valid_o,
  output logic [WW-1:0] data_o
);

  logic          valid_q;
  logic [WW-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (take_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/cop_bridge.sv
module cop_bridge
  import cbr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NR = N_REGION
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic            cmd_auto,
  input  logic [DW-1:0]   cmd_lo,
  input  logic [DW-1:0]   cmd_hi,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*DW-1:0] rsp_data,
  output logic            busy,
  output logic            err,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [NR-1:0]   bus_sel,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata
);

  localparam int WW = 2 * DW;
  localparam logic [AW-1:0] STEP_WORD  = AW'(DW / 8);
  localparam logic [AW-1:0] STEP_DWORD = AW'(WW / 8);

  cbr_op_e         op;
  logic            accept, is_wr, is_iss, is_col;
  logic            seq_go, seq_busy, seq_done, seq_err;
  logic            seq_two;
  logic [AW-1:0]   seq_base;
  logic [WW-1:0]   seq_wdata, seq_rdata;
  logic            buf_valid, buf_take;
  logic [WW-1:0]   buf_data;
  logic [AW-1:0]   hold_q;
  logic            rd_inflight_q, rd_auto_q;
  logic            rsp_valid_q, err_q;
  logic [WW-1:0]   rsp_data_q;
  logic            col_hit;

  assign op     = cbr_op_e'(cmd_op);
  assign is_wr  = (op == OP_WRITE);
  assign is_iss = (op == OP_ISSUE);
  assign is_col = (op == OP_COL32) || (op == OP_COL64);

  assign cmd_ready = ~seq_busy & ~rsp_valid_q;
  assign accept    = cmd_valid & cmd_ready;
  assign busy      = cmd_valid & is_col & seq_busy;

  // Sequence launch: explicit write is one beat, everything else two.
  assign seq_go    = accept & (is_wr | is_iss);
  assign seq_base  = cmd_auto ? hold_q : cmd_lo[AW-1:0];
  assign seq_two   = ~(is_wr & ~cmd_auto);
  assign seq_wdata = cmd_auto ? {cmd_hi, cmd_lo} : {{DW{1'b0}}, cmd_hi};

  cbr_beat_seq #(.AW(AW), .DW(DW), .NR(NR)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (seq_go),
    .we_i    (is_wr),
    .two_i   (seq_two),
    .base_i  (seq_base),
    .wdata_i (seq_wdata),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .err_o   (seq_err),
    .rdata_o (seq_rdata),
    .req_o   (bus_req),
    .we_o    (bus_we),
    .addr_o  (bus_addr),
    .wdata_o (bus_wdata),
    .sel_o   (bus_sel),
    .ack_i   (bus_ack),
    .rdata_i (bus_rdata)
  );

  assign col_hit  = accept & is_col & buf_valid;
  assign buf_take = col_hit | (accept & is_iss);

  cbr_rd_buf #(.WW(WW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (seq_done & rd_inflight_q),
    .data_i  (seq_rdata),
    .take_i  (buf_take),
    .valid_o (buf_valid),
    .data_o  (buf_data)
  );

  // Held address and read bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q        <= '0;
      rd_inflight_q <= 1'b0;
      rd_auto_q     <= 1'b0;
    end else begin
      if (seq_done) rd_inflight_q <= 1'b0;
      if (accept && (is_wr || is_iss)) begin
        if (!cmd_auto)  hold_q <= cmd_lo[AW-1:0];
        else if (is_wr) hold_q <= hold_q + STEP_DWORD;
      end
      if (accept && is_iss) begin
        rd_inflight_q <= 1'b1;
        rd_auto_q     <= cmd_auto;
      end
      if (col_hit && rd_auto_q)
        hold_q <= hold_q + ((op == OP_COL64) ? STEP_DWORD : STEP_WORD);
    end
  end

  // Response stage and error pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q <= (seq_done & seq_err) | (accept & is_col & ~buf_valid);
      if (accept && is_col) begin
        rsp_valid_q <= 1'b1;
        if (!buf_valid)          rsp_data_q <= '0;
        else if (op == OP_COL64) rsp_data_q <= buf_data;
        else                     rsp_data_q <= {{DW{1'b0}}, buf_data[DW-1:0]};
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign err       = err_q;

  // R1: a stalled collect is never accepted
  p_busy_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  // R2: an explicit command loads the held address
  p_explicit_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cmd_auto && (is_wr || is_iss)) |=> hold_q == $past(cmd_lo[AW-1:0]));

  // R3: an auto write moves the held address by one double word
  p_auto_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_auto && is_wr) |=> hold_q == $past(hold_q) + STEP_DWORD);

  // R9: an untaken response stays put
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

endmodule

// File: tb/cop_bridge_tb_top.sv
`timescale 1ns/1ps
module cop_bridge_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_auto = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [31:0] cmd_lo = '0, cmd_hi = '0;
  logic        cmd_ready, rsp_valid, busy, err;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        bus_req, bus_we, bus_ack;
  logic [19:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [6:0]  bus_sel;

  always #2.5 clk = ~clk;

  cop_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_auto(cmd_auto), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .busy(busy), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_sel(bus_sel),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int nchk = 0, nerr = 0;
  int err_seen = 0, exp_err = 0;
  int tgt_lat = 0;
  bit saw_busy = 1'b0, done_flag = 1'b0;

  typedef struct {
    logic [19:0] a;
    logic        we;
    logic [31:0] d;
    logic [6:0]  s;
    string       tag;
  } beat_t;

  beat_t       bq[$];
  logic [63:0] rq[$];
  string       rtag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, expv);
    end
  endtask

  // Expected window select, from the map in the requirements (R6)
  function automatic logic [6:0] exp_sel(input logic [19:0] a);
    if (a < 20'h08000)                        return 7'b0000001;
    if (a >= 20'h20000 && a < 20'h40000)      return 7'b0000010;
    if (a >= 20'h94000 && a < 20'h95000)      return 7'b0000100;
    if (a >= 20'h98000 && a < 20'h9A000)      return 7'b0001000;
    if (a >= 20'h9C000 && a < 20'h9D000)      return 7'b0010000;
    if (a >= 20'hA0000 && a < 20'hA1000)      return 7'b0100000;
    if (a >= 20'hA1000 && a < 20'hA2000)      return 7'b1000000;
    return 7'b0;
  endfunction

  function automatic logic [31:0] pat(input logic [19:0] a);
    return {12'hC3A, a};
  endfunction

  // Target model: acknowledges after tgt_lat waiting cycles
  int tcnt = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
      tcnt      <= 0;
    end else if (bus_ack) begin
      bus_ack <= 1'b0;
      tcnt    <= 0;
    end else if (bus_req) begin
      if (tcnt >= tgt_lat) begin
        bus_ack   <= 1'b1;
        bus_rdata <= pat(bus_addr);
      end else begin
        tcnt <= tcnt + 1;
      end
    end
  end

  // Bus monitor: compares every completed beat with the scoreboard
  logic        prev_wait = 1'b0;
  logic [19:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait)
        chk(bus_req && bus_addr == prev_addr, "R10", "request held until ack",
            {43'h0, bus_req, bus_addr}, {43'h0, 1'b1, prev_addr});
      prev_wait = bus_req && !bus_ack;
      prev_addr = bus_addr;
      if (bus_req && bus_ack) begin
        if (bq.size() == 0) begin
          chk(1'b0, "R7", "unexpected bus beat", {44'h0, bus_addr}, 64'h0);
        end else begin
          beat_t e;
          e = bq.pop_front();
          chk(bus_addr == e.a && bus_we == e.we && bus_sel == e.s, e.tag,
              "beat addr/we/sel", {36'h0, bus_sel, bus_we, bus_addr},
              {36'h0, e.s, e.we, e.a});
          if (e.we)
            chk(bus_wdata == e.d, e.tag, "beat write data",
                {32'h0, bus_wdata}, {32'h0, e.d});
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (rq.size() == 0) begin
          chk(1'b0, "R5", "unexpected response", rsp_data, 64'h0);
        end else begin
          logic [63:0] x;
          string t;
          x = rq.pop_front();
          t = rtag.pop_front();
          chk(rsp_data == x, t, "response data", rsp_data, x);
        end
      end
      if (err) err_seen++;
    end
  end

  // Bench-side model of the held address and outstanding read
  logic [19:0] eh = '0;
  bit          pend = 1'b0, pend_auto = 1'b0;
  logic [31:0] plo = '0, phi = '0;

  task automatic send(input logic [1:0] op, input logic au,
                      input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_auto = au; cmd_lo = lo; cmd_hi = hi;
    #1;
    while (!cmd_ready) begin
      if (busy) saw_busy = 1'b1;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_beat(input logic [19:0] a, input logic we,
                           input logic [31:0] d, input string tag,
                           output bit hole);
    beat_t b;
    hole = (exp_sel(a) == 7'b0);
    if (!hole) begin
      b.a = a; b.we = we; b.d = d; b.s = exp_sel(a); b.tag = tag;
      bq.push_back(b);
    end
  endtask

  task automatic wr_exp(input logic [31:0] addr, input logic [31:0] d,
                        input string tag);
    bit h;
    eh = addr[19:0];
    push_beat(eh, 1'b1, d, tag, h);
    if (h) exp_err++;
    send(2'd0, 1'b0, addr, d);
  endtask

  task automatic wr_auto(input logic [63:0] d, input string tag);
    bit h0, h1;
    push_beat(eh, 1'b1, d[31:0], tag, h0);
    push_beat(eh + 20'd4, 1'b1, d[63:32], tag, h1);
    if (h0 || h1) exp_err++;
    eh = eh + 20'd8;
    send(2'd0, 1'b1, d[31:0], d[63:32]);
  endtask

  task automatic rd_issue(input logic au, input logic [31:0] addr,
                          input string tag);
    bit h0, h1;
    if (!au) eh = addr[19:0];
    push_beat(eh, 1'b0, 32'h0, tag, h0);
    push_beat(eh + 20'd4, 1'b0, 32'h0, tag, h1);
    if (h0 || h1) exp_err++;
    plo = h0 ? 32'h0 : pat(eh);
    phi = h1 ? 32'h0 : pat(eh + 20'd4);
    pend = 1'b1;
    pend_auto = au;
    send(2'd1, au, addr, 32'h0);
  endtask

  task automatic collect(input bit is64, input string tag);
    logic [63:0] x;
    if (pend) begin
      x = is64 ? {phi, plo} : {32'h0, plo};
      if (pend_auto) eh = eh + (is64 ? 20'd8 : 20'd4);
      pend = 1'b0;
    end else begin
      x = 64'h0;
      exp_err++;
    end
    rq.push_back(x);
    rtag.push_back(tag);
    send(is64 ? 2'd3 : 2'd2, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic settle(input string tag);
    repeat (2) @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(err_seen == exp_err, tag, "error pulse count",
        64'(err_seen), 64'(exp_err));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(cmd_ready == 1'b1, "R11", "cmd_ready after reset", 64'(cmd_ready), 64'h1);
    chk(rsp_valid == 1'b0 && bus_req == 1'b0 && err == 1'b0, "R11",
        "rsp_valid/bus_req/err after reset",
        {61'h0, rsp_valid, bus_req, err}, 64'h0);

    // R11/R3: auto writes start from held address 0 and advance by 8
    wr_auto(64'h11112222_33334444, "R11");
    wr_auto(64'h55556666_77778888, "R3");
    settle("R3");

    // R2: upper address bits ignored, explicit write loads held address
    wr_exp(32'hFFF9_4010, 32'hDEAD_0001, "R2");
    wr_auto(64'hAAAA0002_BBBB0003, "R2");
    settle("R2");

    // R6: every window, at both edges where useful
    wr_exp(32'h0002_0000, 32'h0000_0101, "R6");
    wr_exp(32'h0003_FFFC, 32'h0000_0102, "R6");
    wr_exp(32'h0009_8000, 32'h0000_0103, "R6");
    wr_exp(32'h0009_9FFC, 32'h0000_0104, "R6");
    wr_exp(32'h0009_C000, 32'h0000_0105, "R6");
    wr_exp(32'h000A_0000, 32'h0000_0106, "R6");
    wr_exp(32'h000A_1FFC, 32'h0000_0107, "R6");
    wr_exp(32'h0000_7FFC, 32'h0000_0108, "R6");
    settle("R6");

    // R7: writes into gaps are dropped and flagged
    wr_exp(32'h0000_8000, 32'hBAD0_0001, "R7");
    settle("R7");
    wr_exp(32'h000A_2000, 32'hBAD0_0002, "R7");
    settle("R7");
    wr_exp(32'h000F_FFFC, 32'hBAD0_0003, "R7");
    settle("R7");

    // R1/R4/R5: slow target, collect offered straight after issue
    tgt_lat = 6;
    saw_busy = 1'b0;
    rd_issue(1'b0, 32'h0000_0100, "R4");
    collect(1'b1, "R5");
    chk(saw_busy, "R1", "busy while collect waits", 64'(saw_busy), 64'h1);
    settle("R1");
    tgt_lat = 1;

    // R4/R5: auto reads continue from explicit address; pointer steps 4 then 8
    rd_issue(1'b1, 32'h0, "R4");
    collect(1'b0, "R5");
    rd_issue(1'b1, 32'h0, "R4");
    collect(1'b1, "R5");
    wr_auto(64'h0C0C0C0C_0D0D0D0D, "R5");
    settle("R5");

    // R7: read that straddles the end of the shared memory
    rd_issue(1'b0, 32'h0000_7FFC, "R7");
    collect(1'b1, "R7");
    settle("R7");
    // R7: read entirely inside a gap
    rd_issue(1'b0, 32'h0005_0000, "R7");
    collect(1'b0, "R7");
    settle("R7");

    // R8: collect with nothing outstanding
    collect(1'b1, "R8");
    settle("R8");

    // R9: response held under back-pressure
    rsp_ready = 1'b0;
    rd_issue(1'b0, 32'h0009_C010, "R9");
    collect(1'b0, "R9");
    repeat (4) @(negedge clk);
    chk(rsp_valid == 1'b1, "R9", "rsp_valid held", 64'(rsp_valid), 64'h1);
    chk(rsp_data == {32'h0, pat(20'h9C010)}, "R9", "rsp_data held",
        rsp_data, {32'h0, pat(20'h9C010)});
    chk(cmd_ready == 1'b0, "R1", "cmd_ready low while response pending",
        64'(cmd_ready), 64'h0);
    rsp_ready = 1'b1;
    settle("R9");

    chk(bq.size() == 0, "R10", "beats left unseen", 64'(bq.size()), 64'h0);
    chk(rq.size() == 0, "R5", "responses left unseen", 64'(rq.size()), 64'h0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not complete, got %0d checks expected end", nchk);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule